// File: doc/BRIEF.md
# Long-Press Reset Pulse Generator

This block turns a push-button held down for a long time into a single reset pulse of fixed width. The button request is active-low and is sampled on the block clock. In normal operation a press must stay low without a break for a qualification time of `DELAY_CYCLES` clocks before the reset output is driven low. The output then stays low for exactly `PULSE_CYCLES` clocks, whatever the button does in the meantime. A short press, released before the qualification time ends, leaves the output untouched and throws away the partial count.

A mode strap selects a factory-test mode in which the reset pulse starts as soon as the button is seen low. The pulse width is the same as in normal mode. The strap is meant to be static. It is captured while the block is resting with the button released, and it is captured from the pin during power-on reset. Any change made while the button is held is ignored.

After each pulse the block waits for the button to come back high before it can start another count, so a button that stays pressed produces one pulse and no more. Both inputs pass through a two-stage synchronizer. The output is given twice: as an active-low level, and as a matching drive-low enable for an open-drain pad outside the block.

Top module: `lp_reset_pulser`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rst_n_o` is 1 and `rst_drv_o` is 0. The mode strap is captured from the `dly_sel_i` pin during reset, so a press made right after reset with the strap high gives a test-mode pulse.
- R2: With the strap low, count edges from the first rising edge at which `btn_n_i` is low. If the button is held for `DELAY_CYCLES` consecutive edges, `rst_n_o` goes low after edge `DELAY_CYCLES+2`. If it is held for only `DELAY_CYCLES-1` edges, `rst_n_o` stays high.
- R3: A release that is seen before the qualification completes returns the block to rest, clears the count, and leaves the output high. The next press needs the full `DELAY_CYCLES` again, and the counter holds zero while the block is at rest.
- R4: Each pulse holds `rst_n_o` low for exactly `PULSE_CYCLES` consecutive clocks, even if the button is released part-way through the pulse.
- R5: A button held low past the end of a pulse produces no second pulse until it has been released.
- R6: After a long hold, one released cycle at the pin is enough to re-arm the block. A press that follows it qualifies with the same timing as in R2.
- R7: With the strap high (1 = test mode), `rst_n_o` goes low after the third rising edge counted from the first edge with the button low. It stays low for `PULSE_CYCLES` clocks.
- R8: A change of `dly_sel_i` made while the button is low has no effect on the press in progress. The new value takes effect for presses that start after the block has rested with the button high.
- R9: `rst_drv_o` is always the inverse of `rst_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| btn_n_i | input | 1 | Active-low button reset request |
| dly_sel_i | input | 1 | Mode strap, 1 selects zero-delay test mode |
| rst_n_o | output | 1 | Active-low reset pulse level |
| rst_drv_o | output | 1 | Drive-low enable for an external open-drain pad |

## Verification
A count left over from a broken press would show up as a pulse that starts too early on the next press. The error appears at `rst_n_o` a few clocks before the edge given in R2. A missing re-arm guard would show up during a long hold, as a second low window right after the first pulse. A mode register that loads at the wrong time would show up as a test-mode or normal-mode pulse on the wrong press. Each of these faults appears within one press-and-release sequence, which is at most `DELAY_CYCLES+PULSE_CYCLES` plus a few clocks. A miscounted pulse width shows at the rising edge of `rst_n_o`.

// File: rtl/lpr_pkg.sv
`timescale 1ns/1ps
package lpr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } lpr_state_e;
endpackage

// File: rtl/lpr_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer. During reset every stage preloads the pin value,
// so that a static strap is valid from the first cycle after reset.
module lpr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= d;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= d;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpr_ctrl.sv
`timescale 1ns/1ps
module lpr_ctrl
  import lpr_pkg::*;
#(
  parameter int DELAY_CYCLES = 8,
  parameter int PULSE_CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_s,      // synchronized, active low
  input  logic dsel_s,     // synchronized strap
  input  logic dsel_strap, // raw strap, captured during reset
  output logic pulse_nxt
);
  localparam int MAXC = (DELAY_CYCLES > PULSE_CYCLES) ? DELAY_CYCLES : PULSE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] D_LAST = CW'(DELAY_CYCLES - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PULSE_CYCLES - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam bit            NO_QUAL = (DELAY_CYCLES <= 1);

  lpr_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            mode_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!btn_s) begin
          if (mode_q || NO_QUAL) begin
            state_d = ST_PULSE;
          end else begin
            state_d = ST_COUNT;
            cnt_d   = ONE;
          end
        end
      end
      ST_COUNT: begin
        if (btn_s) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == D_LAST) begin
          state_d = ST_PULSE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_PULSE: begin
        if (cnt_q == P_LAST) begin
          cnt_d   = '0;
          state_d = btn_s ? ST_IDLE : ST_HOLD;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_HOLD: begin
        cnt_d = '0;
        if (btn_s) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Strap capture: from the pin in reset, afterwards only at rest with button up.
  always_ff @(posedge clk) begin
    if (rst)                              mode_q <= dsel_strap;
    else if (state_q == ST_IDLE && btn_s) mode_q <= dsel_s;
  end

  assign pulse_nxt = (state_d == ST_PULSE);

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (cnt_q == '0));
  // R5
  rearm_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && !btn_s) |=> (state_q == ST_HOLD));
  // R8
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !btn_s |=> $stable(mode_q));
  // R2
  full_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COUNT && state_d == ST_PULSE) |-> (cnt_q == D_LAST));
  // R7
  test_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && mode_q && !btn_s) |=> (state_q == ST_PULSE));
endmodule

// File: rtl/lpr_drive.sv
`timescale 1ns/1ps
module lpr_drive #(
  parameter int PULSE_CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_nxt,
  output logic rst_n_o,
  output logic rst_drv_o
);
  localparam int RW = $clog2(PULSE_CYCLES + 2);
  localparam logic [RW-1:0] P_VAL = RW'(PULSE_CYCLES);
  localparam logic [RW-1:0] R_ONE = RW'(1);

  logic          lvl_q, drv_q;
  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b1;
      drv_q <= 1'b0;
    end else begin
      lvl_q <= !pulse_nxt;
      drv_q <= pulse_nxt;
    end
  end

  assign rst_n_o   = lvl_q;
  assign rst_drv_o = drv_q;

  // Checker-side run length of the low level.
  always_ff @(posedge clk) begin
    if (rst)                                 low_run_q <= '0;
    else if (!lvl_q && low_run_q != '1)      low_run_q <= low_run_q + R_ONE;
    else if (lvl_q)                          low_run_q <= '0;
  end

  // R9
  drive_pair_chk: assert property (@(posedge clk) disable iff (rst)
    drv_q == !lvl_q);
  // R4
  pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
    low_run_q <= P_VAL);
  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_q) |-> (low_run_q == P_VAL));
endmodule

// File: rtl/lp_reset_pulser.sv
`timescale 1ns/1ps
module lp_reset_pulser #(
  parameter int DELAY_CYCLES = 8,
  parameter int PULSE_CYCLES = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n_i,
  input  logic dly_sel_i,
  output logic rst_n_o,
  output logic rst_drv_o
);
  logic [1:0] sync_q;
  logic       pulse_nxt;

  lpr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({btn_n_i, dly_sel_i}),
    .q   (sync_q)
  );

  lpr_ctrl #(.DELAY_CYCLES(DELAY_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .btn_s      (sync_q[1]),
    .dsel_s     (sync_q[0]),
    .dsel_strap (dly_sel_i),
    .pulse_nxt  (pulse_nxt)
  );

  lpr_drive #(.PULSE_CYCLES(PULSE_CYCLES)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .pulse_nxt (pulse_nxt),
    .rst_n_o   (rst_n_o),
    .rst_drv_o (rst_drv_o)
  );
endmodule

// File: tb/lp_reset_pulser_tb.sv
`timescale 1ns/1ps
module lp_reset_pulser_tb;
  localparam int D = 8;
  localparam int P = 5;

  typedef struct {
    logic  exp_n;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1;
  logic dsel = 1'b0;
  logic rst_n, rst_drv;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  lp_reset_pulser #(.DELAY_CYCLES(D), .PULSE_CYCLES(P)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .btn_n_i   (btn_n),
    .dly_sel_i (dsel),
    .rst_n_o   (rst_n),
    .rst_drv_o (rst_drv)
  );

  function automatic logic exp_level(int i, int len, bit tm);
    if (tm) return !(len >= 1 && i >= 2 && i <= 1 + P);
    return !(len >= D && i >= D + 1 && i <= D + P);
  endfunction

  // Driver: button low for the first len cycles, optional strap change.
  task automatic run_seq(int len, int total, bit tm, string req,
                         int chg_at = -1, logic chg_val = 1'b0);
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      btn_n = (i < len) ? 1'b0 : 1'b1;
      if (i == chg_at) dsel = chg_val;
      sb_q.push_back('{exp_n: exp_level(i, len, tm), req: req});
    end
    @(negedge clk);
  endtask

  // Monitor: compares each edge's result a quarter period after the edge.
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rst_n !== it.exp_n) begin
        errors++;
        $display("FAIL %s: rst_n_o=%b expected %b at %0t", it.req, rst_n, it.exp_n, $time);
      end
      checks++;
      if (rst_drv !== !it.exp_n) begin
        errors++;
        $display("FAIL R9: rst_drv_o=%b expected %b at %0t", rst_drv, !it.exp_n, $time);
      end
    end
  end

  task automatic check_reset_out(string req);
    checks++;
    if (rst_n !== 1'b1 || rst_drv !== 1'b0) begin
      errors++;
      $display("FAIL %s: rst_n_o=%b rst_drv_o=%b expected 1/0", req, rst_n, rst_drv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_out("R1");
    rst = 1'b0;
    @(negedge clk);
    check_reset_out("R1");
    run_seq(0, 4, 1'b0, "R1");
    // R2 boundary: one short of the qualification, then exactly enough
    run_seq(D - 1, D + P + 4, 1'b0, "R2");
    run_seq(D, D + P + 4, 1'b0, "R2");
    // R3 short press, single released cycle, then a full press counts from zero
    run_seq(D - 1, D, 1'b0, "R3");
    run_seq(D, D + P + 4, 1'b0, "R3");
    // R4 release in the middle of the pulse
    run_seq(D + 2, D + P + 4, 1'b0, "R4");
    // R5 long hold gives a single pulse; R6 one released cycle re-arms
    run_seq(D + P + 12, D + P + 13, 1'b0, "R5");
    run_seq(D, D + P + 4, 1'b0, "R6");
    // R8 strap raised mid-press: this press keeps normal timing
    run_seq(D, D + P + 6, 1'b0, "R8", 2, 1'b1);
    run_seq(0, 4, 1'b0, "R8");
    // R7 strap now captured at rest: test-mode pulse
    run_seq(3, P + 6, 1'b1, "R7");
    // R8 strap lowered at rest: normal timing again
    run_seq(0, 6, 1'b0, "R8", 0, 1'b0);
    run_seq(D, D + P + 4, 1'b0, "R8");
    // R1 reset with strap high: first press is test-mode
    dsel = 1'b1;
    rst  = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_out("R1");
    rst = 1'b0;
    @(negedge clk);
    check_reset_out("R1");
    run_seq(2, P + 6, 1'b1, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule